// File: doc/BRIEF.md
# Narrow-Word Memory on a Wide Masked Array

This block presents a deep, narrow memory to its user: a logical store of `LOG_DEPTH` words, each `LOG_W` bits wide, with one write port and one read port. Internally the words are kept in a shallower, wider array of `PHYS_W`-bit rows. Each row holds `PHYS_W / LOG_W` logical words side by side, called lanes, and every lane has its own write-enable bit. A logical address is split into two parts. Its low bits choose the lane and the remaining upper bits choose the row.

On a write, the narrow data is placed into the chosen lane of an otherwise zero wide word. The mask bit of that lane alone is raised, so the neighbouring words in the same row stay as they are. On a read, the row address is registered in the array, and the lane index is registered alongside it on the same edge. The output then selects the matching slice of the returned row, one cycle after the request. The wide array is a behavioural model inside the block.

The parameters are checked at elaboration. The ratio of physical to logical width must be a power of two of at least 2. The logical depth must divide into at least two rows of that many lanes.

Top module: `mem_reshape`

## Requirements
- R1: Every logical address from 0 to `LOG_DEPTH-1` holds its own `LOG_W`-bit word. Data written at an address is returned by a later read of that address.
- R2: The lane is the low log2(`PHYS_W/LOG_W`) bits of the logical address and the row is the rest. A write changes only its own lane, and the other words in the same row keep their values.
- R3: A write presented while `wr_en` is low changes no stored word.
- R4: When `rd_en` is high at a rising `rd_clk` edge, `rd_data` shows the word at `rd_addr` after that edge. Back-to-back reads return one word per cycle.
- R5: While `rd_en` is low, changes on `rd_addr` do not affect `rd_data`. The captured address is held.
- R6: `rd_data` follows the stored content at the captured address. A write to that address becomes visible on `rd_data` after the write edge, with no new read.
- R7: While `rst_ni` is low, the captured read address is logical address 0, so `rd_data` shows word 0. Writes are accepted during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low reset of the read capture registers |
| wr_clk | input | 1 | Write port clock |
| wr_en | input | 1 | Write enable |
| wr_addr | input | log2(LOG_DEPTH) | Logical write address |
| wr_data | input | LOG_W | Logical write data |
| rd_clk | input | 1 | Read port clock |
| rd_en | input | 1 | Read enable, captures `rd_addr` |
| rd_addr | input | log2(LOG_DEPTH) | Logical read address |
| rd_data | output | LOG_W | Word at the captured address |

## Verification
The bench builds the block with its defaults: 2-bit words, 256 entries and 8-bit rows, which gives four lanes over 64 rows. At this size every logical address can be written and read back. A second pass rewrites only the two middle lanes of every row, so each untouched neighbour shows whether the lane mask leaked. The same small configuration also makes it cheap to cover the held-address, follow-the-write and reset-address cases at specific addresses.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction
endpackage

// File: rtl/mrw_write_steer.sv
module mrw_write_steer #(
    parameter int LOG_W = 2,
    parameter int PHYS_W = 8,
    parameter int LANES = PHYS_W / LOG_W,
    parameter int LB = $clog2(LANES)
) (
    input  logic [LB-1:0]     lane,
    input  logic [LOG_W-1:0]  data_in,
    output logic [PHYS_W-1:0] wide_data,
    output logic [LANES-1:0]  lane_mask
);
    always_comb begin
        wide_data = '0;
        lane_mask = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane == LB'(k)) begin
                wide_data[k*LOG_W +: LOG_W] = data_in;
                lane_mask[k] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mrw_wide_array.sv
module mrw_wide_array #(
    parameter int PHYS_W = 8,
    parameter int LANES = 4,
    parameter int ROWS = 64,
    parameter int RB = $clog2(ROWS),
    localparam int GRAN = PHYS_W / LANES
) (
    input  logic              rst_ni,
    input  logic              wr_clk,
    input  logic              we,
    input  logic [RB-1:0]     waddr,
    input  logic [PHYS_W-1:0] wdata,
    input  logic [LANES-1:0]  wmask,
    input  logic              rd_clk,
    input  logic              re,
    input  logic [RB-1:0]     raddr,
    output logic [PHYS_W-1:0] rdata
);
    typedef struct packed {
        logic [RB-1:0] row;
    } rd_state_t;

    logic [PHYS_W-1:0] mem [ROWS];
    rd_state_t st_d, st_q;

    always_ff @(posedge wr_clk) begin
        if (we) begin
            for (int k = 0; k < LANES; k++) begin
                if (wmask[k]) mem[waddr][k*GRAN +: GRAN] <= wdata[k*GRAN +: GRAN];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (re) st_d.row = raddr;
    end

    always_ff @(posedge rd_clk or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata = mem[st_q.row];

    logic [PHYS_W-1:0] mask_bits;
    always_comb begin
        for (int k = 0; k < LANES; k++) mask_bits[k*GRAN +: GRAN] = {GRAN{wmask[k]}};
    end

    AST_MASK_SINGLE: assert property (@(posedge wr_clk) disable iff (!rst_ni)
        we |-> $onehot(wmask)); // R2
    AST_DATA_IN_LANE: assert property (@(posedge wr_clk) disable iff (!rst_ni)
        we |-> ((wdata & ~mask_bits) == '0)); // R2
    AST_ROW_CAPTURE: assert property (@(posedge rd_clk) disable iff (!rst_ni)
        re |=> (st_q.row == $past(raddr))); // R4
endmodule

// File: rtl/mrw_read_select.sv
module mrw_read_select #(
    parameter int LOG_W = 2,
    parameter int PHYS_W = 8,
    parameter int LANES = PHYS_W / LOG_W,
    parameter int LB = $clog2(LANES)
) (
    input  logic              rst_ni,
    input  logic              rd_clk,
    input  logic              re,
    input  logic [LB-1:0]     lane_in,
    input  logic [PHYS_W-1:0] row_data,
    output logic [LOG_W-1:0]  rd_data
);
    typedef struct packed {
        logic [LB-1:0] lane;
    } sel_state_t;

    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (re) st_d.lane = lane_in;
    end

    always_ff @(posedge rd_clk or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < LANES; k++) begin
            if (st_q.lane == LB'(k)) rd_data = row_data[k*LOG_W +: LOG_W];
        end
    end

    AST_LANE_CAPTURE: assert property (@(posedge rd_clk) disable iff (!rst_ni)
        re |=> (st_q.lane == $past(lane_in))); // R4
    AST_LANE_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_ni)
        !re |=> $stable(st_q.lane)); // R5
endmodule

// File: rtl/mem_reshape.sv
module mem_reshape #(
    parameter int LOG_W = 2,
    parameter int LOG_DEPTH = 256,
    parameter int PHYS_W = 8,
    localparam int LANES = PHYS_W / LOG_W,
    localparam int LB = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int ROWS = LOG_DEPTH / LANES,
    localparam int RB = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int AW = LB + RB
) (
    input  logic             rst_ni,
    input  logic             wr_clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LOG_W-1:0] wr_data,
    input  logic             rd_clk,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [LOG_W-1:0] rd_data
);
    import mrw_pkg::*;

    generate
        if ((PHYS_W % LOG_W) != 0 || LANES < 2 || !is_pow2(LANES))
            $error("physical width must be a power-of-two multiple (>=2) of logical width");
        if ((LOG_DEPTH % LANES) != 0 || ROWS < 2 || !is_pow2(LOG_DEPTH))
            $error("logical depth must be a power of two covering at least two rows");
    endgenerate

    logic [PHYS_W-1:0] wide_wdata;
    logic [LANES-1:0]  wide_mask;
    logic [PHYS_W-1:0] wide_rdata;

    mrw_write_steer #(.LOG_W(LOG_W), .PHYS_W(PHYS_W), .LANES(LANES), .LB(LB)) u_steer (
        .lane      (wr_addr[LB-1:0]),
        .data_in   (wr_data),
        .wide_data (wide_wdata),
        .lane_mask (wide_mask)
    );

    mrw_wide_array #(.PHYS_W(PHYS_W), .LANES(LANES), .ROWS(ROWS), .RB(RB)) u_array (
        .rst_ni (rst_ni),
        .wr_clk (wr_clk),
        .we     (wr_en),
        .waddr  (wr_addr[AW-1:LB]),
        .wdata  (wide_wdata),
        .wmask  (wide_mask),
        .rd_clk (rd_clk),
        .re     (rd_en),
        .raddr  (rd_addr[AW-1:LB]),
        .rdata  (wide_rdata)
    );

    mrw_read_select #(.LOG_W(LOG_W), .PHYS_W(PHYS_W), .LANES(LANES), .LB(LB)) u_rsel (
        .rst_ni   (rst_ni),
        .rd_clk   (rd_clk),
        .re       (rd_en),
        .lane_in  (rd_addr[LB-1:0]),
        .row_data (wide_rdata),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/mem_reshape_bench.sv
module mem_reshape_bench;
    localparam int LW = 2;
    localparam int LD = 256;
    localparam int PW = 8;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [LW-1:0] wr_data = '0;
    logic [LW-1:0] rd_data;

    int total = 0;
    int bad = 0;
    logic [LW-1:0] expv [LD];

    always #10 clk = ~clk;

    mem_reshape #(.LOG_W(LW), .LOG_DEPTH(LD), .PHYS_W(PW)) u_mem_reshape (
        .rst_ni(rst_ni), .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_clk(clk), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [LW-1:0] pat1(input int a);
        return LW'((a ^ (a >> 2) ^ (a >> 5)) & 3);
    endfunction
    function automatic logic [LW-1:0] pat2(input int a);
        return LW'((~a + (a >> 3)) & 3);
    endfunction

    task automatic check(input string req, input logic [LW-1:0] got, input logic [LW-1:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h", req, got, want);
        end
    endtask

    task automatic do_write(input int a, input logic [LW-1:0] d, input logic en);
        @(negedge clk);
        wr_en = en; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (en) expv[a] = d;
    endtask

    task automatic do_read(input int a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog: got=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R7: writes accepted while reset is held
        for (int a = 0; a < LD; a++) do_write(a, pat1(a), 1'b1);
        @(negedge clk);
        check("R7", rd_data, expv[0]);
        rd_en = 1'b1; rd_addr = AW'(77);
        @(negedge clk);
        check("R7", rd_data, expv[0]);
        rd_en = 1'b0;
        rst_ni = 1'b1;

        // R1: full sweep readback
        for (int a = 0; a < LD; a++) begin
            do_read(a);
            check("R1", rd_data, expv[a]);
        end

        // R2: rewrite lanes 1 and 2 only, neighbours must survive
        for (int a = 0; a < LD; a++)
            if ((a % 4) == 1 || (a % 4) == 2) do_write(a, pat2(a), 1'b1);
        for (int a = 0; a < LD; a++) begin
            do_read(a);
            if ((a % 4) == 1 || (a % 4) == 2) check("R1", rd_data, expv[a]);
            else check("R2", rd_data, expv[a]);
        end

        // R3: disabled write leaves word unchanged
        do_write(9, ~expv[9], 1'b0);
        do_read(9);
        check("R3", rd_data, expv[9]);

        // R4: back-to-back reads, one word per cycle
        @(negedge clk);
        rd_en = 1'b1;
        for (int a = 40; a < 56; a++) begin
            rd_addr = AW'(a);
            @(negedge clk);
            check("R4", rd_data, expv[a]);
        end
        rd_en = 1'b0;

        // R5: address moves with rd_en low
        do_read(10);
        check("R4", rd_data, expv[10]);
        for (int a = 11; a < 15; a++) begin
            rd_addr = AW'(a);
            @(negedge clk);
            check("R5", rd_data, expv[10]);
        end

        // R6: write to captured address shows without a new read
        do_write(10, ~expv[10], 1'b1);
        check("R6", rd_data, expv[10]);
        do_write(8, ~expv[8], 1'b1);
        check("R6", rd_data, expv[10]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule